// File: doc/BRIEF.md
# Amplifier Offset Calibration Sequencer

This block is a hardware state machine that runs the offset-trim search of an on-chip amplifier without software stepping. A start pulse switches the amplifier on, selects the user trim set and puts the amplifier into calibration mode. The block then works through up to four searches, one for each input pair (N, P) in each power mode (normal, low-power). Each search raises a 5-bit trim code one step at a time from zero. After every code change it waits a programmable number of clock cycles for the analog comparator to settle, then samples the calibration flag.

A search ends on the first sample where the flag has switched to its end value, and the code in use at that moment goes into the matching field of the normal or low-power trim word. If the code runs out at its top value, that value is stored and a failure bit is set for the pass. A 4-bit mask lets the user skip passes for modes that are not used. When the last enabled pass is finished, calibration mode is released, a one-cycle done pulse is given and the block returns to idle. The amplifier stays enabled and keeps using the user trim values.

Top module: `ocal_seq`

## Requirements
- R1: After reset every output is 0.
- R2: An accepted start sets `amp_en_o`, `user_trim_o`, `cal_on_o` and `busy_o` from the next cycle on. `pass_en_i` and `settle_i` are captured at that same edge.
- R3: Passes run in index order 0,1,2,3. Pass index bit 1 drives `lp_sel_o` (1 means low-power) and bit 0 drives `pol_sel_o` (0 means N pair, 1 means P pair). This gives: 0 = normal/N, 1 = normal/P, 2 = low-power/N, 3 = low-power/P.
- R4: Within a pass, `trim_code_o` starts at 0 and only ever increases by exactly 1.
- R5: Each trim code is held for `settle_i`+1 cycles, and the flag is sampled only at the end of that window. With E enabled passes and n_k codes visited in pass k, `busy_o` is high for (E+1) + Σ n_k·(`settle_i`+1) + 1 cycles.
- R6: A pass with polarity 0 ends at the first sample with `cal_flag_i`=1. A pass with polarity 1 ends at the first sample with `cal_flag_i`=0. The code in use at that sample is the result.
- R7: Each result is stored in its own field. The N result goes to bits [4:0] and the P result to bits [9:5]. Normal-mode results go to `trim_norm_o` and low-power results to `trim_lp_o`.
- R8: A pass whose `pass_en_i` bit is 0 is skipped: its field keeps its earlier value and no code is driven for it.
- R9: If the flag has not switched when the code is 31, the pass stores 31 and sets bit k of `fail_o`. `fail_o` is cleared at an accepted start and is otherwise held.
- R10: On completion `cal_on_o` drops and `done_o` is high for exactly one cycle, during which `busy_o` is still high. After that `busy_o` is low, while `amp_en_o` and `user_trim_o` stay high.
- R11: A start pulse while `busy_o` is high has no effect on the run, its timing or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| pass_en_i | input | 4 | Pass enable mask, bit k enables pass k |
| settle_i | input | SETTLE_W | Settling wait in cycles after each code change |
| cal_flag_i | input | 1 | Comparator flag from the amplifier |
| amp_en_o | output | 1 | Amplifier enable |
| user_trim_o | output | 1 | Select user trim values |
| cal_on_o | output | 1 | Calibration mode on |
| lp_sel_o | output | 1 | Low-power mode select for the current pass |
| pol_sel_o | output | 1 | Pair select / flag polarity for the current pass |
| trim_code_o | output | TRIM_W | Trim code under test |
| trim_norm_o | output | 2*TRIM_W | Normal-mode trim word {P, N} |
| trim_lp_o | output | 2*TRIM_W | Low-power trim word {P, N} |
| fail_o | output | 4 | Per-pass failure bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two situations are the hardest to reach from the ports. The first is a flag sampled before the settling window is over. The second is a pass that runs out of codes. The bench comparator model gives the "not yet switched" answer until the code and pass select have been stable for the programmed window, so a sequencer that samples early overshoots and stores a code that is too large. Each pass gets a threshold computed by the bench, and some thresholds lie above 31, so exhaustion and the failure bits come up naturally while the bench sweeps every mask and several settling times.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

    localparam int PASS_N = 4;
    localparam int PASS_IW = $clog2(PASS_N);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PICK   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } ocal_state_e;

endpackage

// File: rtl/ocal_settle_timer.sv
module ocal_settle_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))) // R5
        else $error("settle timer did not count down");

endmodule

// File: rtl/ocal_pass_pick.sv
module ocal_pass_pick #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0] mask_i,
    input  logic [IW:0]  from_i,
    output logic         found_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = mask_i[g] && (int'(from_i) <= g);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ocal_seq.sv
module ocal_seq
    import ocal_pkg::*;
#(
    parameter int TRIM_W   = 5,
    parameter int SETTLE_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [PASS_N-1:0]     pass_en_i,
    input  logic [SETTLE_W-1:0]   settle_i,
    input  logic                  cal_flag_i,
    output logic                  amp_en_o,
    output logic                  user_trim_o,
    output logic                  cal_on_o,
    output logic                  lp_sel_o,
    output logic                  pol_sel_o,
    output logic [TRIM_W-1:0]     trim_code_o,
    output logic [2*TRIM_W-1:0]   trim_norm_o,
    output logic [2*TRIM_W-1:0]   trim_lp_o,
    output logic [PASS_N-1:0]     fail_o,
    output logic                  busy_o,
    output logic                  done_o
);

    localparam logic [TRIM_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        ocal_state_e           st;
        logic [PASS_IW:0]      from;
        logic [PASS_IW-1:0]    cur;
        logic [TRIM_W-1:0]     code;
        logic [PASS_N-1:0]     mask;
        logic [SETTLE_W-1:0]   settle;
        logic [PASS_N-1:0]     fail;
        logic [2*TRIM_W-1:0]   tnorm;
        logic [2*TRIM_W-1:0]   tlp;
        logic                  amp_en;
        logic                  utrim;
        logic                  cal_on;
        logic                  busy;
        logic                  done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               tmr_load;
    logic               tmr_zero;
    logic               pick_found;
    logic [PASS_IW-1:0] pick_idx;
    logic               hit;

    ocal_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (ctl_q.settle),
        .zero_o     (tmr_zero)
    );

    ocal_pass_pick #(.N(PASS_N)) u_pick (
        .mask_i  (ctl_q.mask),
        .from_i  (ctl_q.from),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // polarity 0 ends on flag high, polarity 1 ends on flag low
    assign hit = (cal_flag_i != ctl_q.cur[0]);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st     = ST_PICK;
                    ctl_d.from   = '0;
                    ctl_d.mask   = pass_en_i;
                    ctl_d.settle = settle_i;
                    ctl_d.fail   = '0;
                    ctl_d.amp_en = 1'b1;
                    ctl_d.utrim  = 1'b1;
                    ctl_d.cal_on = 1'b1;
                    ctl_d.busy   = 1'b1;
                end
            end
            ST_PICK: begin
                if (pick_found) begin
                    ctl_d.cur  = pick_idx;
                    ctl_d.code = '0;
                    ctl_d.st   = ST_WAIT;
                    tmr_load   = 1'b1;
                end else begin
                    ctl_d.st     = ST_FINISH;
                    ctl_d.cal_on = 1'b0;
                    ctl_d.done   = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    if (hit || ctl_q.code == CODE_MAX) begin
                        if (ctl_q.cur[1]) begin
                            ctl_d.tlp[ctl_q.cur[0]*TRIM_W +: TRIM_W] = ctl_q.code;
                        end else begin
                            ctl_d.tnorm[ctl_q.cur[0]*TRIM_W +: TRIM_W] = ctl_q.code;
                        end
                        if (!hit) begin
                            ctl_d.fail[ctl_q.cur] = 1'b1;
                        end
                        ctl_d.from = {1'b0, ctl_q.cur} + (PASS_IW+1)'(1);
                        ctl_d.st   = ST_PICK;
                    end else begin
                        ctl_d.code = ctl_q.code + TRIM_W'(1);
                        tmr_load   = 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.busy = 1'b0;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign amp_en_o    = ctl_q.amp_en;
    assign user_trim_o = ctl_q.utrim;
    assign cal_on_o    = ctl_q.cal_on;
    assign lp_sel_o    = ctl_q.cur[1];
    assign pol_sel_o   = ctl_q.cur[0];
    assign trim_code_o = ctl_q.code;
    assign trim_norm_o = ctl_q.tnorm;
    assign trim_lp_o   = ctl_q.tlp;
    assign fail_o      = ctl_q.fail;
    assign busy_o      = ctl_q.busy;
    assign done_o      = ctl_q.done;

    AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |-> (amp_en_o && user_trim_o && cal_on_o)) // R2
        else $error("setup outputs dropped during run");

    AST_CODE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && $past(ctl_q.st) == ST_PICK) |-> (trim_code_o == '0)) // R4
        else $error("pass did not start at code zero");

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && $past(ctl_q.st) == ST_WAIT)
        |-> (trim_code_o == $past(trim_code_o) || trim_code_o == $past(trim_code_o) + TRIM_W'(1))) // R4
        else $error("trim code jumped");

    AST_MASK_RESPECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT) |-> ctl_q.mask[ctl_q.cur]) // R8
        else $error("disabled pass searched");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) // R10
        else $error("done longer than one cycle");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cal_on_o && !done_o)) // R10
        else $error("calibration active while idle");

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o) // R11
        else $error("run ended without done");

endmodule

// File: tb/tb_ocal_seq.sv
module tb_ocal_seq;

    localparam int TW = 5;
    localparam int SW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    pass_en_i = '0;
    logic [SW-1:0] settle_i = '0;
    logic          cal_flag_i;
    logic          amp_en_o, user_trim_o, cal_on_o, lp_sel_o, pol_sel_o;
    logic [TW-1:0] trim_code_o;
    logic [2*TW-1:0] trim_norm_o, trim_lp_o;
    logic [3:0]    fail_o;
    logic          busy_o, done_o;

    ocal_seq #(.TRIM_W(TW), .SETTLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pass_en_i(pass_en_i),
        .settle_i(settle_i), .cal_flag_i(cal_flag_i), .amp_en_o(amp_en_o),
        .user_trim_o(user_trim_o), .cal_on_o(cal_on_o), .lp_sel_o(lp_sel_o),
        .pol_sel_o(pol_sel_o), .trim_code_o(trim_code_o), .trim_norm_o(trim_norm_o),
        .trim_lp_o(trim_lp_o), .fail_o(fail_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int thr [4];
    int model_settle = 0;
    int exp_field [4];

    // comparator model: answers "not switched" until code and pass are stable long enough
    logic [7:0] key_prev = '0;
    int stab = 0;
    always @(posedge clk) begin
        if ({cal_on_o, lp_sel_o, pol_sel_o, trim_code_o} != key_prev) stab <= 0;
        else if (stab < 1000000) stab <= stab + 1;
        key_prev <= {cal_on_o, lp_sel_o, pol_sel_o, trim_code_o};
    end

    always_comb begin
        int p;
        logic ideal;
        p = {30'd0, lp_sel_o, pol_sel_o};
        ideal = pol_sel_o ? (int'(trim_code_o) < thr[p]) : (int'(trim_code_o) >= thr[p]);
        if (!cal_on_o) cal_flag_i = 1'b0;
        else if (stab >= model_settle - 1) cal_flag_i = ideal;
        else cal_flag_i = pol_sel_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] mask, input int s, input int t0, input int t1,
                       input int t2, input int t3, input bit poke);
        int exp_busy, busy_cnt, done_cnt, n_en, steps, fexp;
        bit hung;
        thr[0] = t0; thr[1] = t1; thr[2] = t2; thr[3] = t3;
        model_settle = s;
        exp_busy = 0; n_en = 0; fexp = 0;
        for (int k = 0; k < 4; k++) begin
            if (mask[k]) begin
                steps = (thr[k] > 31 ? 31 : thr[k]) + 1;
                exp_busy += steps * (s + 1);
                n_en++;
                exp_field[k] = (thr[k] > 31) ? 31 : thr[k];
                if (thr[k] > 31) fexp |= (1 << k);
            end
        end
        exp_busy += n_en + 2;
        @(negedge clk);
        pass_en_i = mask; settle_i = SW'(s); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; pass_en_i = ~mask; settle_i = SW'(s + 7);
        check(amp_en_o && user_trim_o && cal_on_o && busy_o, "R2 setup after start",
              {amp_en_o, user_trim_o, cal_on_o, busy_o}, 15);
        busy_cnt = 0; done_cnt = 0; hung = 0;
        while (busy_o) begin
            busy_cnt++;
            if (done_o) begin
                done_cnt++;
                check(!cal_on_o, "R10 cal off at done", cal_on_o, 0);
            end
            if (poke && busy_cnt == 3) start_i = 1'b1;
            else start_i = 1'b0;
            if (busy_cnt > 20000) begin hung = 1; break; end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(!hung, "R5 run terminates", busy_cnt, exp_busy);
        check(busy_cnt == exp_busy, poke ? "R11 R5 busy length with extra start" : "R5 busy length",
              busy_cnt, exp_busy);
        check(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
        check(amp_en_o && user_trim_o && !cal_on_o, "R10 state after done",
              {amp_en_o, user_trim_o, cal_on_o}, 6);
        check(int'(trim_norm_o[4:0]) == exp_field[0], "R6 R7 R3 normal N field", trim_norm_o[4:0], exp_field[0]);
        check(int'(trim_norm_o[9:5]) == exp_field[1], "R6 R7 R3 normal P field", trim_norm_o[9:5], exp_field[1]);
        check(int'(trim_lp_o[4:0]) == exp_field[2], "R6 R7 R8 low-power N field", trim_lp_o[4:0], exp_field[2]);
        check(int'(trim_lp_o[9:5]) == exp_field[3], "R6 R7 R8 low-power P field", trim_lp_o[9:5], exp_field[3]);
        check(int'(fail_o) == fexp, "R9 fail bits", fail_o, fexp);
        repeat (2) @(negedge clk);
        check(!busy_o && !done_o, "R10 idle after run", {busy_o, done_o}, 0);
    endtask

    initial begin
        #(8 * 190000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin thr[k] = 0; exp_field[k] = 0; end
        repeat (3) @(negedge clk);
        check({amp_en_o, user_trim_o, cal_on_o, busy_o, done_o, fail_o, trim_norm_o, trim_lp_o, trim_code_o} == '0,
              "R1 reset outputs", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !cal_on_o, "R1 idle after reset", busy_o, 0);
        // corner cases
        run(4'b1111, 1, 0, 0, 0, 0, 0);
        run(4'b1111, 2, 31, 31, 31, 31, 0);
        run(4'b1111, 1, 40, 32, 33, 50, 1);
        run(4'b0000, 3, 5, 5, 5, 5, 1);
        run(4'b0101, 0, 7, 9, 12, 14, 0);
        run(4'b1010, 4, 3, 32, 6, 1, 1);
        // sweep all masks over two settling times
        for (int s = 1; s <= 3; s += 2) begin
            for (int m = 0; m < 16; m++) begin
                run(4'(m), s, (m * 7 + s) % 34, (m * 5 + 11 + s) % 34,
                    (m * 3 + 22 + s) % 34, (m * 13 + 2 + s) % 34, m[0]);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule